// File: doc/BRIEF.md
# Rotating Window Register File

This block holds a bank of physical general-purpose registers of which only a sixteen-entry slice is visible at any time. The slice starts at a window base counted in groups of four registers. Logical register numbers from the datapath are turned into physical indices by adding four times the base, modulo the physical count. A slice that runs past the last physical register therefore continues at register 0. Procedure calls and returns move the slice, so a callee sees fresh registers while the caller's values remain in the bank.

The window base changes under three commands. An absolute load keeps only the legal low bits of a full-width value. A relative rotate adds a signed four-bit step. A restore reloads a base that was saved earlier by the surrounding control logic. Next to the base, the block keeps a live-group vector with one bit per four-register group. The set and clear strobes act on the bit selected by the base that results from the command of the same cycle. Instruction decoding, exception generation and status bits stay outside the block and arrive as control inputs.

Top module: `winreg_file`

## Requirements
- R1: After reset, win_base is 0 and win_start is 16'h0001, so only group 0 is live.
- R2: A read port returns physical register (4*win_base + logical index) mod 64, combinationally, including windows that wrap past register 63 to register 0.
- R3: With wr_en high at a rising clock edge, wr_data is stored in physical register (4*win_base + wr_idx) mod 64 and can be read from the next cycle on.
- R4: When a write and a window command occur in the same cycle, the write address uses the base as it was before that cycle's update.
- R5: win_cmd 2'b01 loads the base from bits [3:0] of base_wr_val. Bits [31:4] are ignored.
- R6: win_cmd 2'b10 adds rot_imm, sign-extended from bit 3 (range -8 to +7), to the base modulo 16.
- R7: win_cmd 2'b11 loads the base from saved_base.
- R8: win_cmd 2'b00 leaves the base unchanged, whatever base_wr_val, rot_imm and saved_base carry.
- R9: ws_set sets bit N of win_start, where N is the base after this cycle's command. All other bits are unchanged.
- R10: ws_clr clears bit N of win_start, with N chosen as in R9. When ws_set and ws_clr are both high, the bit ends up set.
- R11: The two read ports are independent: each returns the register for its own logical index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Logical index for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Logical index for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Logical index to write |
| wr_data | input | 32 | Write data |
| win_cmd | input | 2 | 00 hold, 01 absolute, 10 rotate, 11 restore |
| base_wr_val | input | 32 | Value for the absolute load (low 4 bits used) |
| rot_imm | input | 4 | Signed rotate step |
| saved_base | input | 4 | Base restored by the restore command |
| ws_set | input | 1 | Set the live bit of the resulting base |
| ws_clr | input | 1 | Clear the live bit of the resulting base |
| win_base | output | 4 | Current window base |
| win_start | output | 16 | Live-group vector |

## Verification
The assertions check the following on every cycle: the reset values, the result of the absolute, restore and hold commands, the effect of the live-bit strobes on the bit of the new base, and that each write reaches the register it addresses. The full index arithmetic can only be shown by the bench's sweeps. These cover every base with every logical index on both read ports, including windows that wrap, and every base combined with every rotate step. The ordering between a write and a window move in the same cycle is also checked only by bench scenarios.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
    typedef enum logic [1:0] {
        WCMD_HOLD    = 2'b00,
        WCMD_ABS     = 2'b01,
        WCMD_ROT     = 2'b10,
        WCMD_RESTORE = 2'b11
    } win_cmd_e;
endpackage

// File: rtl/winreg_window_ctrl.sv
module winreg_window_ctrl
    import winreg_pkg::*;
#(
    parameter int NUM_GROUPS = 16,
    parameter int BASE_W     = 4,
    parameter int DATA_W     = 32,
    parameter int ROT_W      = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            cmd,
    input  logic [DATA_W-1:0]     abs_val,
    input  logic [ROT_W-1:0]      rot_imm,
    input  logic [BASE_W-1:0]     saved_base,
    input  logic                  ws_set,
    input  logic                  ws_clr,
    output logic [BASE_W-1:0]     base_q,
    output logic [NUM_GROUPS-1:0] start_q
);
    typedef struct packed {
        logic [BASE_W-1:0]     base;
        logic [NUM_GROUPS-1:0] start;
    } win_state_t;

    win_state_t st_d, st_q;
    logic [BASE_W-1:0] rot_delta;
    logic              abs_hi_unused;
    win_cmd_e          cmd_e;

    assign cmd_e         = win_cmd_e'(cmd);
    assign abs_hi_unused = ^abs_val[DATA_W-1:BASE_W];

    // Sign extension (or truncation) of the rotate step to base width
    generate
        if (BASE_W > ROT_W) begin : g_ext
            assign rot_delta = {{(BASE_W-ROT_W){rot_imm[ROT_W-1]}}, rot_imm};
        end else begin : g_trunc
            assign rot_delta = rot_imm[BASE_W-1:0];
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        unique case (cmd_e)
            WCMD_ABS:     st_d.base = abs_val[BASE_W-1:0];
            WCMD_ROT:     st_d.base = st_q.base + rot_delta;
            WCMD_RESTORE: st_d.base = saved_base;
            default:      st_d.base = st_q.base;
        endcase
        // live-bit strobes act on the resulting base; set has priority
        if (ws_clr) st_d.start[st_d.base] = 1'b0;
        if (ws_set) st_d.start[st_d.base] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.base  <= '0;
            st_q.start <= NUM_GROUPS'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign base_q  = st_q.base;
    assign start_q = st_q.start;

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (base_q == '0) && (start_q == NUM_GROUPS'(1)));

    a_r5_abs_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == WCMD_ABS) |=> base_q == $past(abs_val[BASE_W-1:0]));

    a_r7_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == WCMD_RESTORE) |=> base_q == $past(saved_base));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == WCMD_HOLD) |=> $stable(base_q));

    a_r9_ws_set: assert property (@(posedge clk) disable iff (!rst_n)
        ws_set |=> start_q[base_q]);

    a_r10_ws_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (ws_clr && !ws_set) |=> !start_q[base_q]);
endmodule

// File: rtl/winreg_index_map.sv
module winreg_index_map #(
    parameter int BASE_W      = 4,
    parameter int LIDX_W      = 4,
    parameter int PIDX_W      = 6,
    parameter int GROUP_SHIFT = 2
) (
    input  logic [BASE_W-1:0] base,
    input  logic [LIDX_W-1:0] lidx,
    output logic [PIDX_W-1:0] pidx
);
    logic [PIDX_W-1:0] origin;

    // Natural wrap of the PIDX_W-bit sum gives the modulo on a power-of-two bank
    always_comb begin
        origin = PIDX_W'(base) << GROUP_SHIFT;
        pidx   = origin + PIDX_W'(lidx);
    end
endmodule

// File: rtl/winreg_storage.sv
module winreg_storage #(
    parameter int NUM_PHYS = 64,
    parameter int DATA_W   = 32,
    parameter int PIDX_W   = 6,
    parameter int NUM_RD   = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_RD-1:0][PIDX_W-1:0]  rd_idx,
    output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data,
    input  logic                           wr_en,
    input  logic [PIDX_W-1:0]              wr_idx,
    input  logic [DATA_W-1:0]              wr_data
);
    logic [DATA_W-1:0] mem_d [NUM_PHYS];
    logic [DATA_W-1:0] mem_q [NUM_PHYS];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[wr_idx] = wr_data;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    generate
        for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
            assign rd_data[g] = mem_q[rd_idx[g]];
        end
    endgenerate

    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
    parameter int NUM_PHYS   = 64,
    parameter int WIN_REGS   = 16,
    parameter int GROUP_SIZE = 4,
    parameter int DATA_W     = 32,
    parameter int ROT_W      = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [$clog2(WIN_REGS)-1:0]            rd_a_idx,
    output logic [DATA_W-1:0]                      rd_a_data,
    input  logic [$clog2(WIN_REGS)-1:0]            rd_b_idx,
    output logic [DATA_W-1:0]                      rd_b_data,
    input  logic                                   wr_en,
    input  logic [$clog2(WIN_REGS)-1:0]            wr_idx,
    input  logic [DATA_W-1:0]                      wr_data,
    input  logic [1:0]                             win_cmd,
    input  logic [DATA_W-1:0]                      base_wr_val,
    input  logic [ROT_W-1:0]                       rot_imm,
    input  logic [$clog2(NUM_PHYS/GROUP_SIZE)-1:0] saved_base,
    input  logic                                   ws_set,
    input  logic                                   ws_clr,
    output logic [$clog2(NUM_PHYS/GROUP_SIZE)-1:0] win_base,
    output logic [NUM_PHYS/GROUP_SIZE-1:0]         win_start
);
    localparam int NUM_GROUPS  = NUM_PHYS / GROUP_SIZE;
    localparam int BASE_W      = $clog2(NUM_GROUPS);
    localparam int PIDX_W      = $clog2(NUM_PHYS);
    localparam int LIDX_W      = $clog2(WIN_REGS);
    localparam int GROUP_SHIFT = $clog2(GROUP_SIZE);
    localparam int NUM_RD      = 2;
    localparam int NUM_MAP     = NUM_RD + 1;

    logic [BASE_W-1:0]                base_q;
    logic [NUM_GROUPS-1:0]            start_q;
    logic [NUM_MAP-1:0][LIDX_W-1:0]   lidx_all;
    logic [NUM_MAP-1:0][PIDX_W-1:0]   pidx_all;
    logic [NUM_RD-1:0][PIDX_W-1:0]    rd_pidx;
    logic [NUM_RD-1:0][DATA_W-1:0]    rd_word;

    winreg_window_ctrl #(
        .NUM_GROUPS (NUM_GROUPS),
        .BASE_W     (BASE_W),
        .DATA_W     (DATA_W),
        .ROT_W      (ROT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (win_cmd),
        .abs_val    (base_wr_val),
        .rot_imm    (rot_imm),
        .saved_base (saved_base),
        .ws_set     (ws_set),
        .ws_clr     (ws_clr),
        .base_q     (base_q),
        .start_q    (start_q)
    );

    // index 0: read A, 1: read B, 2: write; all use the pre-update base
    assign lidx_all = {wr_idx, rd_b_idx, rd_a_idx};

    generate
        for (genvar g = 0; g < NUM_MAP; g++) begin : g_map
            winreg_index_map #(
                .BASE_W      (BASE_W),
                .LIDX_W      (LIDX_W),
                .PIDX_W      (PIDX_W),
                .GROUP_SHIFT (GROUP_SHIFT)
            ) u_map (
                .base (base_q),
                .lidx (lidx_all[g]),
                .pidx (pidx_all[g])
            );
        end
        for (genvar r = 0; r < NUM_RD; r++) begin : g_rdsel
            assign rd_pidx[r] = pidx_all[r];
        end
    endgenerate

    winreg_storage #(
        .NUM_PHYS (NUM_PHYS),
        .DATA_W   (DATA_W),
        .PIDX_W   (PIDX_W),
        .NUM_RD   (NUM_RD)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rd_pidx),
        .rd_data (rd_word),
        .wr_en   (wr_en),
        .wr_idx  (pidx_all[NUM_RD]),
        .wr_data (wr_data)
    );

    assign rd_a_data = rd_word[0];
    assign rd_b_data = rd_word[1];
    assign win_base  = base_q;
    assign win_start = start_q;
endmodule

// File: tb/winreg_file_bench.sv
module winreg_file_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  rd_a_idx, rd_b_idx, wr_idx, rot_imm, saved_base;
    logic [31:0] rd_a_data, rd_b_data, wr_data, base_wr_val;
    logic        wr_en, ws_set, ws_clr;
    logic [1:0]  win_cmd;
    logic [3:0]  win_base;
    logic [15:0] win_start;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] model [64];

    always #4 clk = ~clk;   // 125 MHz

    winreg_file u_winreg_file (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .win_cmd(win_cmd), .base_wr_val(base_wr_val), .rot_imm(rot_imm),
        .saved_base(saved_base), .ws_set(ws_set), .ws_clr(ws_clr),
        .win_base(win_base), .win_start(win_start)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 0; wr_idx = 0; wr_data = 0; win_cmd = 2'b00;
        base_wr_val = 0; rot_imm = 0; saved_base = 0; ws_set = 0; ws_clr = 0;
    endtask

    task automatic op(input logic [1:0] c, input logic [31:0] av, input logic [3:0] ri,
                      input logic [3:0] sb, input logic s, input logic cl);
        win_cmd = c; base_wr_val = av; rot_imm = ri; saved_base = sb; ws_set = s; ws_clr = cl;
        cyc();
        idle();
    endtask

    function automatic int pmap(input int b, input int l);
        return (4 * b + l) % 64;
    endfunction

    initial begin
        rst_n = 0; rd_a_idx = 0; rd_b_idx = 0;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 base", 32'(win_base), 32'd0);
        chk("R1 start", 32'(win_start), 32'h0001);
        cyc();
        chk("R1 base after idle", 32'(win_base), 32'd0);

        // R3/R2: fill every base/logical pair, later writes overwrite earlier ones
        for (int b = 0; b < 16; b++) begin
            op(2'b01, 32'(b), 0, 0, 0, 0);
            for (int l = 0; l < 16; l++) begin
                wr_en = 1; wr_idx = 4'(l); wr_data = 32'hC0DE0000 ^ 32'(b * 256 + l);
                model[pmap(b, l)] = wr_data;
                cyc();
            end
            wr_en = 0;
        end
        // R2/R11: read every window on both ports, including wrapping windows
        for (int b = 0; b < 16; b++) begin
            op(2'b01, 32'(b), 0, 0, 0, 0);
            for (int l = 0; l < 16; l++) begin
                rd_a_idx = 4'(l); rd_b_idx = 4'(15 - l);
                #1;
                chk("R2 port A map", rd_a_data, model[pmap(b, l)]);
                chk("R11 port B map", rd_b_data, model[pmap(b, 15 - l)]);
            end
        end

        // R6: every base and every signed step
        for (int b = 0; b < 16; b++) begin
            for (int i = 0; i < 16; i++) begin
                int d;
                d = (i >= 8) ? i - 16 : i;
                op(2'b01, 32'(b), 0, 0, 0, 0);
                op(2'b10, 0, 4'(i), 0, 0, 0);
                chk("R6 rotate", 32'(win_base), 32'(((b + d) % 16 + 16) % 16));
            end
        end

        // R5: upper bits ignored
        op(2'b01, 32'hFFFF_FFF3, 0, 0, 0, 0);
        chk("R5 abs masked", 32'(win_base), 32'd3);
        op(2'b01, 32'h0000_0010, 0, 0, 0, 0);
        chk("R5 abs masked", 32'(win_base), 32'd0);
        op(2'b01, 32'h1234_567E, 0, 0, 0, 0);
        chk("R5 abs masked", 32'(win_base), 32'd14);

        // R7: restore all values
        for (int s = 0; s < 16; s++) begin
            op(2'b01, 32'(15 - s), 0, 0, 0, 0);
            op(2'b11, 0, 0, 4'(s), 0, 0);
            chk("R7 restore", 32'(win_base), 32'(s));
        end

        // R8: hold ignores command operands
        op(2'b01, 32'd9, 0, 0, 0, 0);
        op(2'b00, 32'd5, 4'd3, 4'd7, 0, 0);
        chk("R8 hold", 32'(win_base), 32'd9);

        // R4: write with rotate uses the old base (15 -> phys 62)
        op(2'b01, 32'd15, 0, 0, 0, 0);
        wr_en = 1; wr_idx = 4'd2; wr_data = 32'hFEED_0062; rot_imm = 4'd1; win_cmd = 2'b10;
        cyc();
        idle();
        model[62] = 32'hFEED_0062;
        chk("R4 base moved", 32'(win_base), 32'd0);
        rd_a_idx = 4'd2; #1;
        chk("R4 new window untouched", rd_a_data, model[2]);
        op(2'b01, 32'd15, 0, 0, 0, 0);
        rd_a_idx = 4'd2; #1;
        chk("R4 write at old base", rd_a_data, 32'hFEED_0062);
        // R4: write with absolute load (base 0 -> phys 5, not 37)
        op(2'b01, 32'd0, 0, 0, 0, 0);
        wr_en = 1; wr_idx = 4'd5; wr_data = 32'hBEEF_0005; win_cmd = 2'b01; base_wr_val = 32'd8;
        cyc();
        idle();
        rd_a_idx = 4'd5; #1;
        chk("R4 abs: phys 37 untouched", rd_a_data, model[37]);
        op(2'b01, 32'd0, 0, 0, 0, 0);
        rd_a_idx = 4'd5; #1;
        chk("R4 abs: write at old base", rd_a_data, 32'hBEEF_0005);

        // R9/R10: live-group bits follow the resulting base
        chk("R9 start before", 32'(win_start), 32'h0001);
        op(2'b01, 32'd3, 0, 0, 1, 0);
        chk("R9 set with abs", 32'(win_start), 32'h0009);
        op(2'b10, 0, 4'd1, 0, 1, 0);
        chk("R9 set with rotate", 32'(win_start), 32'h0019);
        op(2'b00, 0, 0, 0, 0, 1);
        chk("R10 clear", 32'(win_start), 32'h0009);
        op(2'b00, 0, 0, 0, 1, 1);
        chk("R10 set wins", 32'(win_start), 32'h0019);
        op(2'b10, 0, 4'hF, 0, 0, 1);
        chk("R10 clear after rotate -1", 32'(win_start), 32'h0011);
        chk("R6 rotate -1", 32'(win_base), 32'd3);
        op(2'b11, 0, 0, 4'd0, 0, 1);
        chk("R10 clear with restore", 32'(win_start), 32'h0010);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule